// File: doc/BRIEF.md
# System Mode and Option Configuration Registers

This unit holds the system configuration state of a microcontroller. While reset is held it samples two mode pins and picks one of four operating modes: single-chip, expanded, bootstrap or special test. From that mode it takes the reset values of two byte-wide registers. The mode register holds the boot ROM enable, the special-mode flag and the mode-A flag. The options register holds the line-drive request, the port wired-OR enable, the read-visibility/clock-disable bit and four plain option bits.

Software reads and writes both registers over a simple single-cycle bus. Writes are gated bit by bit. While the special-mode flag is set, every protected bit can be written freely. Once that flag is cleared, the device follows normal rules at once: the flag can never be set again, the boot enable is frozen, and the mode-A bit and the visibility bit each accept a single write until the next reset. Ignored writes give no error response.

The unit also decodes its state into control outputs. It tells whether the boot ROM is mapped and whether a probed address falls in the boot window. It tells whether internal reads are shown on the external bus or whether the clock pin is forced low, and whether the line-drive pulse is enabled.

Top module: `sysopt_regs`

## Requirements
- R1: While `rst_n` is low, the mode is taken from the pins: {B,A} = 10 single-chip, 11 expanded, 00 bootstrap, 01 special test. After reset, the mode register (address 0x3C) reads bit 7 = boot enable (1 only in bootstrap), bit 6 = special flag (1 for bootstrap and special test), bit 5 = mode-A flag (equal to pin A), and bits 4:0 = 0. Pin changes after reset have no effect.
- R2: After reset, the options register (address 0x38) reads bit 7 = line-drive, bit 6 = wired-OR, bit 5 = 0, bit 4 = visibility bit, bits 3:0 = options. All of these are 0 except the visibility bit, which is 1 in special test mode only. Bit 5 always reads 0.
- R3: While the special flag reads 1, writes to the boot enable, special flag, mode-A flag and visibility bit all take effect, any number of times.
- R4: Once the special flag is 0, writing 1 to it has no effect until reset.
- R5: While the special flag is 0, the first write access to the mode register loads the mode-A flag and locks it. Later writes leave it unchanged until reset.
- R6: While the special flag is 0, the first write access to the options register loads the visibility bit and locks it. This lock is separate from the lock in R5.
- R7: Boot enable writes are ignored while the special flag is 0. `boot_rom_mapped` equals boot enable AND the special flag.
- R8: `boot_sel` is 1 exactly when `boot_rom_mapped` is 1 and `probe_addr` lies in 0xBE00..0xBFFF inclusive.
- R9: In modes with pin A = 1 (expanded, special test), `read_vis_en` follows the visibility bit and `clk_pin_low` is 0. In the other modes, `clk_pin_low` follows the visibility bit and `read_vis_en` is 0.
- R10: The line-drive, wired-OR and option bits take every write. `line_drive_en` equals the line-drive bit only in modes with pin A = 1. `wired_or_en` and `opt_bits` mirror their bits.
- R11: A read of any address other than 0x3C or 0x38 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pins sampled while low |
| mode_b_pin | input | 1 | Mode pin B |
| mode_a_pin | input | 1 | Mode pin A |
| reg_addr | input | 6 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `reg_addr` |
| probe_addr | input | 16 | Address checked against the boot window |
| boot_rom_mapped | output | 1 | Boot ROM is in the memory map |
| boot_sel | output | 1 | `probe_addr` hits the mapped boot ROM |
| read_vis_en | output | 1 | Drive internal read data onto the external bus |
| clk_pin_low | output | 1 | Force the clock output pin low |
| line_drive_en | output | 1 | Enable the quarter-cycle high drive pulse |
| wired_or_en | output | 1 | Port wired-OR mode |
| opt_bits | output | 4 | Plain option bits |

## Verification
Each of the four pin combinations is reset and then hit with random byte writes to both registers and to unmapped addresses. Random data often clears the special flag part-way through, so one run covers both the free-write phase and the locked phase. Comparing readback against a bench model separates a lock taken on the first access from one taken on a value change, and separates shared locks from independent ones. Directed probes just outside and inside both window edges, taken in the bootstrap and special-test modes, separate off-by-one window bounds and a mapping that ignores the special flag.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int REG_W = 8;
  localparam int OPT_W = 4;

  // encoding is {pin B, pin A}
  typedef enum logic [1:0] {
    MODE_BOOT   = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_EXP    = 2'b11
  } opmode_t;

  function automatic logic rst_special(opmode_t m);
    return (m == MODE_BOOT) || (m == MODE_TEST);
  endfunction

  function automatic logic rst_boot(opmode_t m);
    return m == MODE_BOOT;
  endfunction

  function automatic logic rst_vis(opmode_t m);
    return m == MODE_TEST;
  endfunction

  function automatic logic has_ext_bus(opmode_t m);
    return (m == MODE_EXP) || (m == MODE_TEST);
  endfunction
endpackage

// File: rtl/sysopt_prot_bit.sv
module sysopt_prot_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_val,
  input  logic wr_req,
  input  logic special,
  input  logic wbit,
  output logic q,
  output logic lock,
  output logic taken
);
  assign taken = wr_req & (special | ~lock);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= rst_val;
      lock <= 1'b0;
    end else begin
      if (taken) q <= wbit;
      if (wr_req && !special) lock <= 1'b1;
    end
  end
endmodule

// File: rtl/sysopt_decode.sv
module sysopt_decode #(
  parameter int PROBE_W = 16,
  parameter logic [PROBE_W-1:0] BOOT_BASE = 16'hBE00,
  parameter logic [PROBE_W-1:0] BOOT_LAST = 16'hBFFF
) (
  input  logic               ext_bus,
  input  logic               boot_en,
  input  logic               special,
  input  logic               vis_bit,
  input  logic               line_bit,
  input  logic [PROBE_W-1:0] probe_addr,
  output logic               boot_rom_mapped,
  output logic               boot_sel,
  output logic               read_vis_en,
  output logic               clk_pin_low,
  output logic               line_drive_en
);
  logic in_win;
  assign in_win          = (probe_addr >= BOOT_BASE) && (probe_addr <= BOOT_LAST);
  assign boot_rom_mapped = boot_en & special;
  assign boot_sel        = boot_rom_mapped & in_win;
  assign read_vis_en     = vis_bit & ext_bus;
  assign clk_pin_low     = vis_bit & ~ext_bus;
  assign line_drive_en   = line_bit & ext_bus;
endmodule

// File: rtl/sysopt_regs.sv
module sysopt_regs
  import sysopt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 6'h3C,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 6'h38,
  parameter int PROBE_W = 16,
  parameter logic [PROBE_W-1:0] BOOT_BASE = 16'hBE00,
  parameter logic [PROBE_W-1:0] BOOT_LAST = 16'hBFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_b_pin,
  input  logic               mode_a_pin,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  input  logic [PROBE_W-1:0] probe_addr,
  output logic               boot_rom_mapped,
  output logic               boot_sel,
  output logic               read_vis_en,
  output logic               clk_pin_low,
  output logic               line_drive_en,
  output logic               wired_or_en,
  output logic [OPT_W-1:0]   opt_bits
);
  localparam int NPROT = 2;  // 0: mode-A flag, 1: visibility bit

  opmode_t pin_mode;
  assign pin_mode = opmode_t'({mode_b_pin, mode_a_pin});

  // named internal events for the checker
  logic mode_wr, opt_wr;
  assign mode_wr = wr_en && (reg_addr == MODE_ADDR);
  assign opt_wr  = wr_en && (reg_addr == OPT_ADDR);

  logic ext_bus_q, smod_q, boot_q, line_q, wor_q;
  logic [OPT_W-1:0] opt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_bus_q <= has_ext_bus(pin_mode);
      smod_q    <= rst_special(pin_mode);
      boot_q    <= rst_boot(pin_mode);
      line_q    <= 1'b0;
      wor_q     <= 1'b0;
      opt_q     <= '0;
    end else begin
      if (mode_wr) begin
        smod_q <= smod_q & wdata[6];
        if (smod_q) boot_q <= wdata[7];
      end
      if (opt_wr) begin
        line_q <= wdata[7];
        wor_q  <= wdata[6];
        opt_q  <= wdata[OPT_W-1:0];
      end
    end
  end

  logic [NPROT-1:0] p_rst, p_req, p_wbit, p_q, p_lock, p_taken;
  assign p_rst  = {rst_vis(pin_mode), mode_a_pin};
  assign p_req  = {opt_wr, mode_wr};
  assign p_wbit = {wdata[4], wdata[5]};

  generate
    for (genvar i = 0; i < NPROT; i++) begin : g_prot
      sysopt_prot_bit u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .rst_val(p_rst[i]),
        .wr_req (p_req[i]),
        .special(smod_q),
        .wbit   (p_wbit[i]),
        .q      (p_q[i]),
        .lock   (p_lock[i]),
        .taken  (p_taken[i])
      );
    end
  endgenerate

  logic mda_q, vis_q, mda_lock, vis_lock, mda_taken, vis_taken;
  assign mda_q     = p_q[0];
  assign vis_q     = p_q[1];
  assign mda_lock  = p_lock[0];
  assign vis_lock  = p_lock[1];
  assign mda_taken = p_taken[0];
  assign vis_taken = p_taken[1];

  always_comb begin
    rdata = '0;
    if (reg_addr == MODE_ADDR)
      rdata = {boot_q, smod_q, mda_q, 5'b0};
    else if (reg_addr == OPT_ADDR)
      rdata = {line_q, wor_q, 1'b0, vis_q, opt_q};
  end

  sysopt_decode #(
    .PROBE_W  (PROBE_W),
    .BOOT_BASE(BOOT_BASE),
    .BOOT_LAST(BOOT_LAST)
  ) u_dec (
    .ext_bus        (ext_bus_q),
    .boot_en        (boot_q),
    .special        (smod_q),
    .vis_bit        (vis_q),
    .line_bit       (line_q),
    .probe_addr     (probe_addr),
    .boot_rom_mapped(boot_rom_mapped),
    .boot_sel       (boot_sel),
    .read_vis_en    (read_vis_en),
    .clk_pin_low    (clk_pin_low),
    .line_drive_en  (line_drive_en)
  );

  assign wired_or_en = wor_q;
  assign opt_bits    = opt_q;
endmodule

// File: rtl/sysopt_regs_chk.sv
module sysopt_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic smod_q,
  input logic boot_q,
  input logic mda_q,
  input logic vis_q,
  input logic mda_lock,
  input logic vis_lock,
  input logic mode_wr,
  input logic opt_wr,
  input logic mda_taken,
  input logic vis_taken,
  input logic boot_rom_mapped,
  input logic read_vis_en,
  input logic clk_pin_low
);
  p_special_stays_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !smod_q |=> !smod_q);

  p_mda_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!smod_q && mda_lock && mode_wr) |=> $stable(mda_q));

  p_mda_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mda_lock |=> mda_lock);

  p_mda_no_take_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mda_lock && !smod_q) |-> !mda_taken);

  p_vis_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!smod_q && vis_lock && opt_wr) |=> $stable(vis_q));

  p_vis_no_take_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_lock && !smod_q) |-> !vis_taken);

  p_boot_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!smod_q && mode_wr) |=> $stable(boot_q));

  p_map_needs_special_r7: assert property (@(posedge clk) disable iff (!rst_n)
    boot_rom_mapped |-> smod_q);

  p_vis_outputs_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(read_vis_en && clk_pin_low));
endmodule

bind sysopt_regs sysopt_regs_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .smod_q         (smod_q),
  .boot_q         (boot_q),
  .mda_q          (mda_q),
  .vis_q          (vis_q),
  .mda_lock       (mda_lock),
  .vis_lock       (vis_lock),
  .mode_wr        (mode_wr),
  .opt_wr         (opt_wr),
  .mda_taken      (mda_taken),
  .vis_taken      (vis_taken),
  .boot_rom_mapped(boot_rom_mapped),
  .read_vis_en    (read_vis_en),
  .clk_pin_low    (clk_pin_low)
);

// File: tb/sysopt_regs_test.sv
`timescale 1ns/1ps
module sysopt_regs_test;
  localparam logic [5:0] A_MODE = 6'h3C;
  localparam logic [5:0] A_OPT  = 6'h38;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_b_pin = 1'b0, mode_a_pin = 1'b0;
  logic [5:0] reg_addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [15:0] probe_addr = '0;
  logic boot_rom_mapped, boot_sel, read_vis_en, clk_pin_low, line_drive_en, wired_or_en;
  logic [3:0] opt_bits;

  always #2.5 clk = ~clk;

  sysopt_regs uut (
    .clk(clk), .rst_n(rst_n), .mode_b_pin(mode_b_pin), .mode_a_pin(mode_a_pin),
    .reg_addr(reg_addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .probe_addr(probe_addr), .boot_rom_mapped(boot_rom_mapped), .boot_sel(boot_sel),
    .read_vis_en(read_vis_en), .clk_pin_low(clk_pin_low), .line_drive_en(line_drive_en),
    .wired_or_en(wired_or_en), .opt_bits(opt_bits)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of the register state
  logic m_boot, m_smod, m_mda, m_vis, m_line, m_wor, m_ext;
  logic [3:0] m_opt;
  logic k_mda, k_vis;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mode_reg();
    return {m_boot, m_smod, m_mda, 5'b0};
  endfunction

  function automatic logic [7:0] exp_opt_reg();
    return {m_line, m_wor, 1'b0, m_vis, m_opt};
  endfunction

  function automatic logic exp_sel(logic [15:0] a);
    return m_boot && m_smod && (a >= 16'hBE00) && (a <= 16'hBFFF);
  endfunction

  task automatic model_reset(logic b, logic a);
    m_ext  = a;
    m_smod = ~b;
    m_boot = ~b & ~a;
    m_mda  = a;
    m_vis  = ~b & a;
    m_line = 0; m_wor = 0; m_opt = '0;
    k_mda = 0; k_vis = 0;
  endtask

  task automatic model_write(logic [5:0] ad, logic [7:0] d);
    if (ad == A_MODE) begin
      if (m_smod) begin
        m_boot = d[7]; m_smod = d[6]; m_mda = d[5];
      end else if (!k_mda) begin
        m_mda = d[5]; k_mda = 1;
      end else k_mda = 1;
    end else if (ad == A_OPT) begin
      m_line = d[7]; m_wor = d[6]; m_opt = d[3:0];
      if (m_smod) m_vis = d[4];
      else if (!k_vis) begin
        m_vis = d[4]; k_vis = 1;
      end
    end
  endtask

  task automatic do_reset(logic b, logic a);
    @(negedge clk);
    rst_n = 0; mode_b_pin = b; mode_a_pin = a; wr_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mode_b_pin = ~b; mode_a_pin = ~a;  // later pin changes must not matter
    model_reset(b, a);
  endtask

  task automatic do_write(logic [5:0] ad, logic [7:0] d);
    @(negedge clk);
    reg_addr = ad; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    model_write(ad, d);
  endtask

  task automatic check_all(string tag);
    reg_addr = A_MODE; #0.5;
    check({tag, " R1/R3/R4/R5/R7 mode reg"}, {8'h0, rdata}, {8'h0, exp_mode_reg()});
    reg_addr = A_OPT; #0.5;
    check({tag, " R2/R6/R10 opt reg"}, {8'h0, rdata}, {8'h0, exp_opt_reg()});
    check({tag, " R7 boot_rom_mapped"}, {15'h0, boot_rom_mapped}, {15'h0, m_boot & m_smod});
    check({tag, " R9 read_vis_en"}, {15'h0, read_vis_en}, {15'h0, m_vis & m_ext});
    check({tag, " R9 clk_pin_low"}, {15'h0, clk_pin_low}, {15'h0, m_vis & ~m_ext});
    check({tag, " R10 outputs"}, {10'h0, line_drive_en, wired_or_en, opt_bits},
          {10'h0, m_line & m_ext, m_wor, m_opt});
    probe_addr = 16'($urandom); #0.5;
    check({tag, " R8 boot_sel random"}, {15'h0, boot_sel}, {15'h0, exp_sel(probe_addr)});
  endtask

  task automatic window_edges();
    logic [15:0] pts [4] = '{16'hBDFF, 16'hBE00, 16'hBFFF, 16'hC000};
    foreach (pts[i]) begin
      probe_addr = pts[i]; #0.5;
      check("R8 boot window edge", {15'h0, boot_sel}, {15'h0, exp_sel(pts[i])});
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int m = 0; m < 4; m++) begin
      logic b, a;
      b = m[1]; a = m[0];
      do_reset(b, a);
      #0.5;
      check_all("reset");
      if (!b) window_edges();
      for (int n = 0; n < 80; n++) begin
        int pick;
        logic [5:0] ad;
        pick = int'($urandom_range(0, 9));
        ad = (pick < 4) ? A_MODE : (pick < 8) ? A_OPT : 6'($urandom);
        do_write(ad, 8'($urandom));
        #0.5;
        check_all("rand");
        if (ad != A_MODE && ad != A_OPT) begin
          reg_addr = ad; #0.5;
          check("R11 unmapped read", {8'h0, rdata}, 16'h0);
        end
      end
    end

    // directed: bootstrap, clear special then try to set it again
    do_reset(1'b0, 1'b0);
    do_write(A_MODE, 8'hA0);
    #0.5; check_all("dir special write");
    do_write(A_MODE, 8'h00);
    do_write(A_MODE, 8'hE0);
    #0.5;
    reg_addr = A_MODE; #0.5;
    check("R4 special cannot be set again", {8'h0, rdata[6], 7'h0}, 16'h0);
    check_all("dir R4/R5");
    // mode-A flag locked by first normal write: 0xE0 tried to set it after lock by 0x00
    check("R5 mode-A locked", {15'h0, rdata[5]}, {15'h0, m_mda});
    // visibility lock is separate: first opt write still lands
    do_write(A_OPT, 8'h10);
    do_write(A_OPT, 8'h00);
    #0.5; reg_addr = A_OPT; #0.5;
    check("R6 vis first write kept", {8'h0, rdata}, 16'h0010);
    check("R9 clock forced low", {15'h0, clk_pin_low}, 16'h1);
    window_edges();

    // directed: special test, boot enable set and mapped
    do_reset(1'b0, 1'b1);
    do_write(A_MODE, 8'hC0);
    #0.5; window_edges();
    check_all("dir test mode");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule